// File: doc/BRIEF.md
# Bus Data Signature Compactor

This block watches a 64-bit read-data bus and a 64-bit write-data bus and compresses every completed, qualified data beat into two 32-bit multiple-input signature registers. The upper register takes data bits [63:32] and the lower register takes bits [31:0]. Each compaction step shifts the signature one place and folds in feedback from a fixed primitive polynomial, 1 + x^10 + x^30 + x^31 + x^32, together with the input word. A running-integrity monitor compares the final signatures against a value known to be good.

Byte strobes zero out inactive lanes before compaction. A read that ends in an error contributes zeros and sets a sticky flag. Read and write compaction are enabled separately, and a debug input freezes all bus-driven activity. A small write-only register port lets software do three things: seed either signature, fold an arbitrary 32-bit value into either signature, and issue an initialize command. A beat counter records how many bus beats were compacted.

Top module: `bus_sig_compactor`

## Requirements
- R1: After reset both signatures, the beat counter and the read-error flag are zero, and read and write compaction are both disabled.
- R2: A beat compacts when `xfer_valid_i` and `xfer_ready_i` are high on the same clock edge and its direction is enabled. Each signature then becomes {s[30:0],0} ^ (s[31] ? 32'hC0000401 : 0) ^ d, with the upper half fed by data bits [63:32] and the lower half by bits [31:0]. The result is visible after that edge.
- R3: Strobe bit k qualifies data bits [8k+7:8k]. A lane whose strobe is low contributes zeros, yet the beat is still compacted and counted.
- R4: A read beat that completes with `xfer_error_i` high compacts zeros in place of the read data and sets `rd_err_o`. The flag stays set until an initialize command.
- R5: A write beat compacts the write data even when `xfer_error_i` is high, and it never sets `rd_err_o`.
- R6: A write to register address 0 sets the read enable from data bit 0 and the write enable from data bit 1. A beat whose direction is disabled changes neither the signatures nor the counter.
- R7: The beat counter (`CNT_W` bits) increments by one for each compacted beat and wraps to zero after its maximum value.
- R8: While `dbg_active_i` is high, bus beats change neither the signatures, the counter nor the error flag. Register writes still take effect.
- R9: A write to address 1 (upper) or address 2 (lower) loads that signature with the written value after the edge. It overrides any bus beat or pending software value for that half, but the beat is still counted.
- R10: A write to address 3 (upper) or address 4 (lower) folds the written value into that signature one cycle after the write. It is applied after any bus beat of the write cycle and before any bus beat of the following cycle.
- R11: A write to address 0 with data bit 2 set clears both signatures, the counter, the error flag and any pending software value. This takes precedence over all other updates in that cycle.
- R12: A cycle with `xfer_valid_i` and `xfer_ready_i` not both high compacts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xfer_valid_i | input | 1 | Data-phase transfer active |
| xfer_ready_i | input | 1 | Transfer completes this cycle |
| xfer_write_i | input | 1 | 1 = write beat, 0 = read beat |
| xfer_error_i | input | 1 | Error response on this beat |
| xfer_strb_i | input | 8 | Per-byte lane strobes |
| rdata_i | input | 64 | Read data bus |
| wdata_i | input | 64 | Write data bus |
| dbg_active_i | input | 1 | Suppresses bus-driven updates |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select (0 ctrl, 1/2 seed hi/lo, 3/4 update hi/lo) |
| reg_wdata_i | input | 32 | Register write data |
| sig_hi_o | output | 32 | Upper-half signature |
| sig_lo_o | output | 32 | Lower-half signature |
| beat_cnt_o | output | CNT_W | Compacted beat count |
| rd_err_o | output | 1 | Sticky read-error flag |

## Verification
The assertions check these rules on every cycle: a signature holds when nothing touches it, seeds load exactly, initialize clears state, and the counter steps once per compacted beat. They also check that the error flag is sticky, that debug mode and stalled cycles freeze the counter, that write errors leave the flag alone, that enables change only on control writes, and that errored reads feed zeros. Only the bench scenarios can show the actual polynomial arithmetic, the lane masking values, the one-cycle ordering of software values behind bus beats, and counter wrap, because the scoreboard model predicts them.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int unsigned SIG_W  = 32;
  localparam int unsigned N_HALF = 2;
  localparam int unsigned REG_AW = 3;
  localparam logic [SIG_W-1:0] SIG_TAPS = 32'hC000_0401;

  localparam logic [REG_AW-1:0] ADDR_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_SEED_HI = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_SEED_LO = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_UPD_HI  = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_UPD_LO  = 3'd4;

  localparam int unsigned CTRL_RD_EN = 0;
  localparam int unsigned CTRL_WR_EN = 1;
  localparam int unsigned CTRL_INIT  = 2;
  localparam int unsigned CTRL_W     = 3;

  function automatic logic [SIG_W-1:0] sig_step(logic [SIG_W-1:0] cur, logic [SIG_W-1:0] din);
    return {cur[SIG_W-2:0], 1'b0} ^ ({SIG_W{cur[SIG_W-1]}} & SIG_TAPS) ^ din;
  endfunction
endpackage

// File: rtl/sig_reg_if.sv
module sig_reg_if
  import sig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              init_o,
  output logic [N_HALF-1:0] seed_we_o,
  output logic [N_HALF-1:0] upd_we_o
);
  logic ctrl_we;
  logic rd_en_q, wr_en_q;

  assign ctrl_we = we_i && (addr_i == ADDR_CTRL);
  assign init_o  = ctrl_we && ctrl_i[CTRL_INIT];

  // half 0 = lower, half 1 = upper
  for (genvar h = 0; h < N_HALF; h++) begin : g_dec
    localparam logic [REG_AW-1:0] SEED_A = (h == 0) ? ADDR_SEED_LO : ADDR_SEED_HI;
    localparam logic [REG_AW-1:0] UPD_A  = (h == 0) ? ADDR_UPD_LO  : ADDR_UPD_HI;
    assign seed_we_o[h] = we_i && (addr_i == SEED_A);
    assign upd_we_o[h]  = we_i && (addr_i == UPD_A);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
    end else if (ctrl_we) begin
      rd_en_q <= ctrl_i[CTRL_RD_EN];
      wr_en_q <= ctrl_i[CTRL_WR_EN];
    end
  end

  assign rd_en_o = rd_en_q;
  assign wr_en_o = wr_en_q;

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable({rd_en_q, wr_en_q})); // R6
endmodule

// File: rtl/sig_lane_mask.sv
module sig_lane_mask #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic              write_i,
  input  logic              error_i,
  input  logic [LANES-1:0]  strb_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dbg_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  output logic              fire_o,
  output logic              rd_err_ev_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] src;

  assign fire_o      = valid_i && ready_i && !dbg_i && (write_i ? wr_en_i : rd_en_i);
  assign rd_err_ev_o = fire_o && !write_i && error_i;
  // errored read data is never trusted
  assign src = write_i ? wdata_i : (error_i ? '0 : rdata_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign data_o[8*k +: 8] = strb_i[k] ? src[8*k +: 8] : 8'h00;
  end

  AST_RD_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !write_i && error_i) |-> (data_o == '0)); // R4
  AST_NO_STROBE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i == '0) |-> (data_o == '0)); // R3
endmodule

// File: rtl/sig_misr.sv
module sig_misr
  import sig_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             seed_we_i,
  input  logic             upd_we_i,
  input  logic [SIG_W-1:0] wdata_i,
  input  logic             fire_i,
  input  logic [SIG_W-1:0] data_i,
  output logic [SIG_W-1:0] sig_o
);
  logic [SIG_W-1:0] sig_q, sig_d;
  logic [SIG_W-1:0] pend_q;
  logic             pend_vld_q;

  // pending software value goes first: it was written before this cycle's beat
  always_comb begin
    sig_d = sig_q;
    if (pend_vld_q) sig_d = sig_step(sig_d, pend_q);
    if (fire_i)     sig_d = sig_step(sig_d, data_i);
    if (seed_we_i)  sig_d = wdata_i;
    if (init_i)     sig_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      sig_q      <= sig_d;
      pend_vld_q <= upd_we_i && !init_i;
      if (upd_we_i) pend_q <= wdata_i;
    end
  end

  assign sig_o = sig_q;

  AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_we_i && !init_i) |=> (sig_o == $past(wdata_i))); // R9
  AST_INIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (sig_o == '0)); // R11
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !seed_we_i && !fire_i && !pend_vld_q) |=> $stable(sig_o)); // R2
  AST_UPD_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_we_i && !fire_i && !pend_vld_q && !init_i) |=> $stable(sig_o)); // R10
endmodule

// File: rtl/sig_beat_cnt.sv
module sig_beat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             fire_i,
  input  logic             rd_err_ev_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (init_i) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (fire_i)      cnt_q <= cnt_q + 1'b1;
      if (rd_err_ev_i) err_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;

  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !init_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !init_i) |=> err_o); // R4
endmodule

// File: rtl/bus_sig_compactor.sv
module bus_sig_compactor
  import sig_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned DATA_W = SIG_W * N_HALF,
  localparam int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_valid_i,
  input  logic              xfer_ready_i,
  input  logic              xfer_write_i,
  input  logic              xfer_error_i,
  input  logic [LANES-1:0]  xfer_strb_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dbg_active_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [SIG_W-1:0]  reg_wdata_i,
  output logic [SIG_W-1:0]  sig_hi_o,
  output logic [SIG_W-1:0]  sig_lo_o,
  output logic [CNT_W-1:0]  beat_cnt_o,
  output logic              rd_err_o
);
  logic              rd_en, wr_en, init;
  logic [N_HALF-1:0] seed_we, upd_we;
  logic              fire, rd_err_ev;
  logic [DATA_W-1:0] bus_data;
  logic [SIG_W-1:0]  sig_half [N_HALF];

  sig_reg_if u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .ctrl_i    (reg_wdata_i[CTRL_W-1:0]),
    .rd_en_o   (rd_en),
    .wr_en_o   (wr_en),
    .init_o    (init),
    .seed_we_o (seed_we),
    .upd_we_o  (upd_we)
  );

  sig_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (xfer_valid_i),
    .ready_i     (xfer_ready_i),
    .write_i     (xfer_write_i),
    .error_i     (xfer_error_i),
    .strb_i      (xfer_strb_i),
    .rdata_i     (rdata_i),
    .wdata_i     (wdata_i),
    .dbg_i       (dbg_active_i),
    .rd_en_i     (rd_en),
    .wr_en_i     (wr_en),
    .fire_o      (fire),
    .rd_err_ev_o (rd_err_ev),
    .data_o      (bus_data)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    sig_misr u_misr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .init_i    (init),
      .seed_we_i (seed_we[h]),
      .upd_we_i  (upd_we[h]),
      .wdata_i   (reg_wdata_i),
      .fire_i    (fire),
      .data_i    (bus_data[h*SIG_W +: SIG_W]),
      .sig_o     (sig_half[h])
    );
  end

  sig_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init),
    .fire_i      (fire),
    .rd_err_ev_i (rd_err_ev),
    .cnt_o       (beat_cnt_o),
    .err_o       (rd_err_o)
  );

  assign sig_lo_o = sig_half[0];
  assign sig_hi_o = sig_half[N_HALF-1];

  AST_DBG_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_active_i && !init) |=> $stable(beat_cnt_o)); // R8
  AST_WR_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && xfer_ready_i && xfer_write_i && !rd_err_o && !init) |=> !rd_err_o); // R5
  AST_STALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(xfer_valid_i && xfer_ready_i) && !init) |=> $stable(beat_cnt_o)); // R12
endmodule

// File: tb/sim_bus_sig_compactor.sv
`timescale 1ns/1ps
module sim_bus_sig_compactor;
  localparam int CW = 4;
  localparam logic [31:0] TAPS = 32'hC000_0401;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        xv, xr, xw, xe, dbg, we;
  logic [7:0]  strb;
  logic [63:0] rd, wd;
  logic [2:0]  addr;
  logic [31:0] rwd;
  logic [31:0] sig_hi, sig_lo;
  logic [CW-1:0] cnt;
  logic        err;

  bus_sig_compactor #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .xfer_valid_i(xv), .xfer_ready_i(xr), .xfer_write_i(xw), .xfer_error_i(xe),
    .xfer_strb_i(strb), .rdata_i(rd), .wdata_i(wd), .dbg_active_i(dbg),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(rwd),
    .sig_hi_o(sig_hi), .sig_lo_o(sig_lo), .beat_cnt_o(cnt), .rd_err_o(err)
  );

  typedef struct {
    logic [31:0]   hi;
    logic [31:0]   lo;
    logic [CW-1:0] cnt;
    logic          err;
    int            cyc;
    string         tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [31:0]   m_hi = '0, m_lo = '0, m_ph = '0, m_pl = '0;
  logic          m_phv = 0, m_plv = 0, m_ren = 0, m_wen = 0, m_err = 0;
  logic [CW-1:0] m_cnt = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] step(logic [31:0] s, logic [31:0] d);
    return {s[30:0], 1'b0} ^ (s[31] ? TAPS : 32'h0) ^ d;
  endfunction

  task automatic drv(input logic v, input logic r, input logic w, input logic e,
                     input logic [7:0] s, input logic [63:0] d, input logic g,
                     input logic rwe, input logic [2:0] a, input logic [31:0] rw,
                     input string tag);
    logic fire, init;
    logic [63:0] src, md;
    logic [31:0] nh, nl;
    exp_t it;
    @(negedge clk);
    xv = v; xr = r; xw = w; xe = e; strb = s; dbg = g;
    rd = w ? ~d : d;
    wd = w ? d : ~d;
    we = rwe; addr = a; rwd = rw;
    fire = v && r && !g && (w ? m_wen : m_ren);
    src  = w ? d : (e ? 64'h0 : d);
    for (int k = 0; k < 8; k++) md[8*k +: 8] = s[k] ? src[8*k +: 8] : 8'h00;
    init = rwe && a == 3'd0 && rw[2];
    nh = m_hi; nl = m_lo;
    if (m_phv) nh = step(nh, m_ph);
    if (m_plv) nl = step(nl, m_pl);
    if (fire) begin
      nh = step(nh, md[63:32]);
      nl = step(nl, md[31:0]);
    end
    if (rwe && a == 3'd1) nh = rw;
    if (rwe && a == 3'd2) nl = rw;
    m_phv = rwe && a == 3'd3;
    m_plv = rwe && a == 3'd4;
    m_ph = rw; m_pl = rw;
    if (fire) m_cnt = m_cnt + 1'b1;
    if (fire && !w && e) m_err = 1'b1;
    if (rwe && a == 3'd0) begin m_ren = rw[0]; m_wen = rw[1]; end
    if (init) begin nh = '0; nl = '0; m_cnt = '0; m_err = 1'b0; end
    m_hi = nh; m_lo = nl;
    it.hi = nh; it.lo = nl; it.cnt = m_cnt; it.err = m_err; it.cyc = cyc; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic bus(input logic w, input logic e, input logic [7:0] s,
                     input logic [63:0] d, input string tag);
    drv(1, 1, w, e, s, d, 0, 0, 3'd0, 32'h0, tag);
  endtask

  task automatic regw(input logic [2:0] a, input logic [31:0] v, input string tag);
    drv(0, 0, 0, 0, 8'h00, 64'h0, 0, 1, a, v, tag);
  endtask

  task automatic idle(input string tag);
    drv(0, 0, 0, 0, 8'h00, 64'h0, 0, 0, 3'd0, 32'h0, tag);
  endtask

  // monitor: compare each expected item one cycle after it was driven
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc < cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (sig_hi !== e.hi || sig_lo !== e.lo || cnt !== e.cnt || err !== e.err) begin
        n_fail++;
        $display("FAIL %s cyc=%0d hi=%h/%h lo=%h/%h cnt=%0d/%0d err=%b/%b",
                 e.tag, e.cyc, sig_hi, e.hi, sig_lo, e.lo, cnt, e.cnt, err, e.err);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    xv = 0; xr = 0; xw = 0; xe = 0; strb = 0; rd = 0; wd = 0; dbg = 0;
    we = 0; addr = 0; rwd = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (sig_hi !== 0 || sig_lo !== 0 || cnt !== 0 || err !== 0) begin
      n_fail++;
      $display("FAIL R1 reset hi=%h lo=%h cnt=%0d err=%b exp 0", sig_hi, sig_lo, cnt, err);
    end
    rst_n = 1'b1;
    // R1: both directions disabled out of reset
    bus(0, 0, 8'hFF, 64'h1111_2222_3333_4444, "R1");
    bus(1, 0, 8'hFF, 64'h5555_6666_7777_8888, "R1");
    // R9: seeds, including top bit set to exercise feedback
    regw(3'd1, 32'h8000_0001, "R9");
    regw(3'd2, 32'hFFFF_0000, "R9");
    regw(3'd0, 32'h3, "R6");
    // R2: full-strobe beats, both directions
    bus(0, 0, 8'hFF, 64'h0, "R2");
    bus(0, 0, 8'hFF, 64'h0123_4567_89AB_CDEF, "R2");
    bus(1, 0, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D, "R2");
    // R3: partial and empty strobes
    bus(0, 0, 8'hA5, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    bus(1, 0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    bus(1, 0, 8'h0F, 64'h1234_5678_9ABC_DEF0, "R3");
    // R12: no completion
    drv(1, 0, 0, 0, 8'hFF, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, 3'd0, 32'h0, "R12");
    drv(0, 1, 1, 0, 8'hFF, 64'hBBBB_BBBB_BBBB_BBBB, 0, 0, 3'd0, 32'h0, "R12");
    // R8: debug blocks bus beats, including an errored read; register writes still work
    drv(1, 1, 0, 1, 8'hFF, 64'hCCCC_CCCC_CCCC_CCCC, 1, 0, 3'd0, 32'h0, "R8");
    drv(1, 1, 1, 0, 8'hFF, 64'hDDDD_DDDD_DDDD_DDDD, 1, 1, 3'd3, 32'h0BAD_F00D, "R8");
    drv(0, 0, 0, 0, 8'h00, 64'h0, 1, 1, 3'd2, 32'h7777_0001, "R8");
    idle("R8");
    // R5: write error does not flag
    bus(1, 1, 8'hFF, 64'h0F0F_0F0F_F0F0_F0F0, "R5");
    // R4: read error zeros data and sets sticky flag
    bus(0, 1, 8'hFF, 64'h9999_9999_9999_9999, "R4");
    bus(0, 0, 8'hFF, 64'h1357_9BDF_2468_ACE0, "R4");
    idle("R4");
    // R6: only reads enabled, then only writes, then none
    regw(3'd0, 32'h1, "R6");
    bus(1, 0, 8'hFF, 64'hEEEE_EEEE_EEEE_EEEE, "R6");
    bus(0, 0, 8'hFF, 64'h0000_0001_0000_0002, "R6");
    regw(3'd0, 32'h2, "R6");
    bus(0, 0, 8'hFF, 64'hEEEE_EEEE_EEEE_EEEE, "R6");
    bus(1, 0, 8'hFF, 64'h0000_0003_0000_0004, "R6");
    regw(3'd0, 32'h0, "R6");
    bus(0, 0, 8'hFF, 64'h5A5A_5A5A_5A5A_5A5A, "R6");
    regw(3'd0, 32'h3, "R6");
    // R9: seed collides with a bus beat; seed wins, beat still counted
    drv(1, 1, 0, 0, 8'hFF, 64'h4242_4242_4242_4242, 0, 1, 3'd1, 32'h1357_2468, "R9");
    // R10: software updates, alone and against bus beats
    regw(3'd3, 32'hA5A5_0001, "R10");
    idle("R10");
    drv(1, 1, 0, 0, 8'hFF, 64'h1111_0000_2222_0000, 0, 1, 3'd4, 32'h8000_0000, "R10");
    bus(0, 0, 8'hFF, 64'h0000_3333_0000_4444, "R10");
    regw(3'd3, 32'h0000_0010, "R10");
    regw(3'd4, 32'h0000_0020, "R10");
    bus(1, 0, 8'hF0, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
    // R9: seed drops a pending software value
    regw(3'd3, 32'h1234_0000, "R9");
    regw(3'd1, 32'h0000_5678, "R9");
    idle("R9");
    // R11: initialize keeps enables from the same write and drops pending value
    regw(3'd4, 32'hFFFF_FFFF, "R11");
    drv(1, 1, 0, 1, 8'hFF, 64'h1, 0, 1, 3'd0, 32'h7, "R11");
    idle("R11");
    // R7: counter wraps
    for (int i = 0; i < 20; i++) bus(i[0], 0, 8'hFF, {32'(i * 7), 32'(i * 13)}, "R7");
    // R2: mixed random beats
    for (int i = 0; i < 40; i++)
      bus(1'($urandom), 0, 8'($urandom), {$urandom, $urandom}, "R2");
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule